// File: doc/BRIEF.md
# Shared FFT Two-Stream Scheduler

This block lets a single FFT engine serve two antenna streams within one fixed pipeline period. Two sample streams arrive together at the sample rate. The block takes one sample of each on every sample strobe, which it derives by dividing the fast clock by `CLK_DIV`. A frame is `FRAME_LEN` samples, and one frame time is one pipeline period of `FRAME_LEN*CLK_DIV` fast clocks.

The work runs as a three-stage pipeline. In the capture stage a frame of both streams is written into one of three buffer sets. In the transform stage the block starts the external FFT engine on stream A and then on stream B, one after the other. The engine reads the buffered samples and writes its results back through an address port. In the release stage the two result frames leave the block, one sample per strobe. The three sets rotate at every period boundary, so no two stages ever share a set.

The block also measures how many fast clocks the engine reported busy in each period, which gives the stage utilization. It flags a period in which the second transform did not complete.

Top module: `fft_pair_sched`

## Requirements
- R1: `sample_stb` is high for exactly one fast clock in every `CLK_DIV` clocks. It is high in the first cycle after reset is released. `in_a` and `in_b` are captured at the rising edge that ends a strobe cycle.
- R2: A pipeline period lasts `FRAME_LEN*CLK_DIV` fast clocks. It ends with the clock in which the `FRAME_LEN`-th sample of the frame is captured.
- R3: A frame captured in period p is offered to the FFT port during period p+1. Its results are released during period p+2. The three buffer sets rotate at every period boundary.
- R4: During a transform period, `fft_rdata` returns, in the same cycle, the buffered word of stream `fft_sel` (0 = A, 1 = B) at `fft_addr`. A word written with `fft_we` and `fft_wdata` replaces that word, and the replacement is what is later released.
- R5: From the second period on, `fft_start` pulses for one clock with `fft_sel`=0 in the first clock of every period. The pulse with `fft_sel`=1 comes in the clock right after `fft_done` is seen for stream A.
- R6: In period 2 and later, each strobe cycle is followed by one clock of `out_valid`. In that clock `out_a` and `out_b` carry result word k of streams A and B, with k rising from 0 to `FRAME_LEN`-1 through the period.
- R7: After reset, and during periods 0 and 1, `out_valid` stays low. `fft_start` stays low during period 0.
- R8: At each period boundary, `util_clks` takes the number of clocks of the ending period in which `fft_busy` was high. It holds that value through the next period and is 0 after reset.
- R9: At each period boundary, `overrun` becomes 1 if the transform stage was active in the ending period and `fft_done` for stream B had not arrived. Otherwise it becomes 0. It holds through the next period and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | DW | Stream A sample |
| in_b | input | DW | Stream B sample |
| sample_stb | output | 1 | Sample-rate strobe; inputs are taken at the edge ending it |
| fft_start | output | 1 | One-clock start request to the FFT engine |
| fft_sel | output | 1 | Stream being transformed (0 = A, 1 = B) |
| fft_busy | input | 1 | Engine busy, counted for utilization |
| fft_done | input | 1 | Engine finished the current stream |
| fft_addr | input | $clog2(FRAME_LEN) | Engine word address into the current buffer |
| fft_we | input | 1 | Engine write strobe |
| fft_wdata | input | DW | Engine result word |
| fft_rdata | output | DW | Buffered word at fft_addr |
| out_valid | output | 1 | Result word valid |
| out_a | output | DW | Stream A result word |
| out_b | output | DW | Stream B result word |
| util_clks | output | $clog2(FRAME_LEN*CLK_DIV+1) | Busy clocks of the previous period |
| overrun | output | 1 | Previous period missed the stream B completion |

## Verification
A captured sample comes back as a result exactly two periods later. It shows in the clock after the strobe cycle that reads it. The bench therefore derives each expected result word from the clock index alone: period, sample index and frame. `util_clks` and `overrun` change only in the first clock of a new period, so the bench reads them on the last clock of one period and the first clock of the next. Start pulses are checked against the period boundary and against the clock after the recorded completion of stream A. All sampling happens on the falling edge.

// File: rtl/fps_pkg.sv
package fps_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_REQA,
      SQ_WAITA,
      SQ_REQB,
      SQ_WAITB,
      SQ_DONE
   } seq_st_t;

   typedef logic [1:0] set_idx_t;

   function automatic set_idx_t set_next(set_idx_t s);
      return (s == 2'd2) ? 2'd0 : s + 2'd1;
   endfunction

   function automatic set_idx_t set_prev(set_idx_t s);
      return (s == 2'd0) ? 2'd2 : s - 2'd1;
   endfunction

endpackage

// File: rtl/fps_timer.sv
module fps_timer
   import fps_pkg::*;
#(
   parameter int CLK_DIV   = 5,
   parameter int FRAME_LEN = 80
) (
   input  logic                          clk,
   input  logic                          rst,
   output logic                          stb,
   output logic                          wrap,
   output logic [$clog2(FRAME_LEN)-1:0]  sidx,
   output set_idx_t                      st_set,
   output set_idx_t                      fx_set,
   output set_idx_t                      ot_set
);
   localparam int AW = $clog2(FRAME_LEN);
   localparam int VW = $clog2(CLK_DIV);

   logic [VW-1:0] div_q;
   logic [AW-1:0] idx_q;
   set_idx_t      rot_q;
   logic          last_div;

   assign last_div = (div_q == VW'(CLK_DIV - 1));
   assign stb      = (div_q == '0);
   assign wrap     = last_div && (idx_q == AW'(FRAME_LEN - 1));
   assign sidx     = idx_q;
   assign st_set   = rot_q;
   assign fx_set   = set_prev(rot_q);
   assign ot_set   = set_next(rot_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q <= '0;
         idx_q <= '0;
         rot_q <= 2'd0;
      end else begin
         div_q <= last_div ? '0 : div_q + VW'(1);
         if (last_div)
            idx_q <= (idx_q == AW'(FRAME_LEN - 1)) ? '0 : idx_q + AW'(1);
         if (wrap)
            rot_q <= set_next(rot_q);
      end
   end

   // R1: the strobe never lasts two clocks
   a_r1_stb_single: assert property (@(posedge clk) disable iff (rst)
      stb |=> !stb);

   // R3: the capture set changes at every boundary
   a_r3_rotate: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (st_set != $past(st_set)));

endmodule

// File: rtl/fps_bank.sv
module fps_bank
   import fps_pkg::*;
#(
   parameter int DW        = 16,
   parameter int FRAME_LEN = 80,
   parameter int SET_ID    = 0
) (
   input  logic                          clk,
   input  set_idx_t                      st_set,
   input  set_idx_t                      fx_set,
   input  logic                          stb,
   input  logic [$clog2(FRAME_LEN)-1:0]  sidx,
   input  logic [DW-1:0]                 in_a,
   input  logic [DW-1:0]                 in_b,
   input  logic                          fx_we,
   input  logic                          fx_sel,
   input  logic [$clog2(FRAME_LEN)-1:0]  fx_addr,
   input  logic [DW-1:0]                 fx_wdata,
   output logic [DW-1:0]                 rd_a,
   output logic [DW-1:0]                 rd_b,
   output logic [DW-1:0]                 fx_rdata
);
   logic [DW-1:0] mem_a [FRAME_LEN];
   logic [DW-1:0] mem_b [FRAME_LEN];
   logic          cap_here, fx_here;

   assign cap_here = (st_set == 2'(SET_ID));
   assign fx_here  = (fx_set == 2'(SET_ID));

   always_ff @(posedge clk) begin
      if (cap_here && stb) begin
         mem_a[sidx] <= in_a;
         mem_b[sidx] <= in_b;
      end else if (fx_here && fx_we) begin
         if (fx_sel) mem_b[fx_addr] <= fx_wdata;
         else        mem_a[fx_addr] <= fx_wdata;
      end
   end

   assign rd_a     = mem_a[sidx];
   assign rd_b     = mem_b[sidx];
   assign fx_rdata = fx_sel ? mem_b[fx_addr] : mem_a[fx_addr];

endmodule

// File: rtl/fps_seq.sv
module fps_seq
   import fps_pkg::*;
#(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wrap,
   input  logic          fft_busy,
   input  logic          fft_done,
   output logic          fft_start,
   output logic          fft_sel,
   output logic          out_ok,
   output logic [CW-1:0] util_clks,
   output logic          overrun
);
   seq_st_t       st_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] util_q;
   logic          ovr_q, fok_q, ook_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= SQ_IDLE;
         cnt_q  <= '0;
         util_q <= '0;
         ovr_q  <= 1'b0;
         fok_q  <= 1'b0;
         ook_q  <= 1'b0;
      end else if (wrap) begin
         st_q   <= SQ_REQA;
         ovr_q  <= fok_q && (st_q != SQ_DONE);
         fok_q  <= 1'b1;
         ook_q  <= fok_q;
         util_q <= cnt_q + CW'(fft_busy);
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(fft_busy);
         case (st_q)
            SQ_REQA:  st_q <= SQ_WAITA;
            SQ_WAITA: if (fft_done) st_q <= SQ_REQB;
            SQ_REQB:  st_q <= SQ_WAITB;
            SQ_WAITB: if (fft_done) st_q <= SQ_DONE;
            default:  st_q <= st_q;
         endcase
      end
   end

   assign fft_start = (st_q == SQ_REQA) || (st_q == SQ_REQB);
   assign fft_sel   = (st_q == SQ_REQB) || (st_q == SQ_WAITB);
   assign out_ok    = ook_q;
   assign util_clks = util_q;
   assign overrun   = ovr_q;

   // R5: start is a single-clock pulse
   a_r5_start_pulse: assert property (@(posedge clk) disable iff (rst)
      fft_start |=> !fft_start);

   // R5: stream B is requested only right after a completion
   a_r5_b_after_done: assert property (@(posedge clk) disable iff (rst)
      (fft_start && fft_sel) |-> $past(fft_done));

   // R9: the flag moves only at a period boundary
   a_r9_ovr_at_wrap: assert property (@(posedge clk) disable iff (rst)
      !$stable(overrun) |-> $past(wrap));

   // R8: the measurement moves only at a period boundary
   a_r8_util_at_wrap: assert property (@(posedge clk) disable iff (rst)
      !$stable(util_clks) |-> $past(wrap));

endmodule

// File: rtl/fft_pair_sched.sv
module fft_pair_sched
   import fps_pkg::*;
#(
   parameter int DW        = 16,
   parameter int FRAME_LEN = 80,
   parameter int CLK_DIV   = 5
) (
   input  logic                                     clk,
   input  logic                                     rst,
   input  logic [DW-1:0]                            in_a,
   input  logic [DW-1:0]                            in_b,
   output logic                                     sample_stb,
   output logic                                     fft_start,
   output logic                                     fft_sel,
   input  logic                                     fft_busy,
   input  logic                                     fft_done,
   input  logic [$clog2(FRAME_LEN)-1:0]             fft_addr,
   input  logic                                     fft_we,
   input  logic [DW-1:0]                            fft_wdata,
   output logic [DW-1:0]                            fft_rdata,
   output logic                                     out_valid,
   output logic [DW-1:0]                            out_a,
   output logic [DW-1:0]                            out_b,
   output logic [$clog2(FRAME_LEN*CLK_DIV+1)-1:0]   util_clks,
   output logic                                     overrun
);
   localparam int AW     = $clog2(FRAME_LEN);
   localparam int PERIOD = FRAME_LEN * CLK_DIV;
   localparam int CW     = $clog2(PERIOD + 1);
   localparam int NSET   = 3;

   if (CLK_DIV < 2) begin : g_bad_div
      $error("CLK_DIV must be at least 2");
   end
   if (FRAME_LEN < 4) begin : g_bad_len
      $error("FRAME_LEN must be at least 4");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end

   logic          wrap, out_ok;
   logic [AW-1:0] sidx;
   set_idx_t      st_set, fx_set, ot_set;
   logic [DW-1:0] rd_a_s [NSET];
   logic [DW-1:0] rd_b_s [NSET];
   logic [DW-1:0] fxr_s  [NSET];

   fps_timer #(.CLK_DIV(CLK_DIV), .FRAME_LEN(FRAME_LEN)) u_timer (
      .clk(clk), .rst(rst), .stb(sample_stb), .wrap(wrap), .sidx(sidx),
      .st_set(st_set), .fx_set(fx_set), .ot_set(ot_set)
   );

   fps_seq #(.CW(CW)) u_seq (
      .clk(clk), .rst(rst), .wrap(wrap), .fft_busy(fft_busy),
      .fft_done(fft_done), .fft_start(fft_start), .fft_sel(fft_sel),
      .out_ok(out_ok), .util_clks(util_clks), .overrun(overrun)
   );

   for (genvar g = 0; g < NSET; g++) begin : g_set
      fps_bank #(.DW(DW), .FRAME_LEN(FRAME_LEN), .SET_ID(g)) u_bank (
         .clk(clk), .st_set(st_set), .fx_set(fx_set), .stb(sample_stb),
         .sidx(sidx), .in_a(in_a), .in_b(in_b), .fx_we(fft_we),
         .fx_sel(fft_sel), .fx_addr(fft_addr), .fx_wdata(fft_wdata),
         .rd_a(rd_a_s[g]), .rd_b(rd_b_s[g]), .fx_rdata(fxr_s[g])
      );
   end

   assign fft_rdata = fxr_s[fx_set];

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_a     <= '0;
         out_b     <= '0;
      end else begin
         out_valid <= sample_stb && out_ok;
         if (sample_stb && out_ok) begin
            out_a <= rd_a_s[ot_set];
            out_b <= rd_b_s[ot_set];
         end
      end
   end

   // R6: every result word follows a strobe cycle
   a_r6_out_after_stb: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(sample_stb));

   // R7: results stay held between strobes
   a_r7_out_hold: assert property (@(posedge clk) disable iff (rst)
      !$past(sample_stb) |-> ($stable(out_a) && $stable(out_b)));

endmodule

// File: tb/sim_fft_pair_sched.sv
module sim_fft_pair_sched;
   localparam int DW  = 16;
   localparam int FL  = 8;
   localparam int CD  = 5;
   localparam int PER = FL * CD;
   localparam int AW  = $clog2(FL);
   localparam int CW  = $clog2(PER + 1);
   localparam int NV  = 6;

   // {base_a, step_a, base_b, step_b}
   localparam logic [63:0] VEC [NV] = '{
      {16'h0000, 16'h0001, 16'h8000, 16'h0003},
      {16'hFFFF, 16'hFFFF, 16'h1234, 16'h0000},
      {16'hAAAA, 16'h0101, 16'h5555, 16'hF00F},
      {16'h0F0F, 16'h2000, 16'h00FF, 16'h0011},
      {16'h7FFF, 16'h0002, 16'hFFFE, 16'h8001},
      {16'h1357, 16'h0246, 16'h9BDF, 16'h1111}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [DW-1:0] in_a = '0, in_b = '0;
   logic sample_stb, fft_start, fft_sel, out_valid, overrun;
   logic [DW-1:0] fft_wdata, fft_rdata, out_a, out_b;
   logic [AW-1:0] fft_addr;
   logic fft_we;
   logic [CW-1:0] util_clks;

   logic eng_busy, eng_done, eng_sel;
   int   ecnt;
   int   lat = 10;
   int   cyc;
   int   last_done = -10;
   int   nout = 0;
   bit   mon_en = 1'b0;
   int   nchk = 0, nfail = 0;

   always #2 clk = ~clk;

   fft_pair_sched #(.DW(DW), .FRAME_LEN(FL), .CLK_DIV(CD)) u0 (
      .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b),
      .sample_stb(sample_stb), .fft_start(fft_start), .fft_sel(fft_sel),
      .fft_busy(eng_busy), .fft_done(eng_done), .fft_addr(fft_addr),
      .fft_we(fft_we), .fft_wdata(fft_wdata), .fft_rdata(fft_rdata),
      .out_valid(out_valid), .out_a(out_a), .out_b(out_b),
      .util_clks(util_clks), .overrun(overrun)
   );

   function automatic logic [DW-1:0] samp(int f, int k, bit sb);
      logic [63:0] v;
      v = VEC[f % NV];
      if (sb) return v[31:16] + v[15:0] * DW'(k);
      return v[63:48] + v[47:32] * DW'(k);
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   // model FFT engine: A results inverted, B results offset by 0x0101
   always @(posedge clk) begin
      if (rst) begin
         eng_busy <= 1'b0;
         eng_done <= 1'b0;
         eng_sel  <= 1'b0;
         ecnt     <= 0;
      end else begin
         eng_done <= 1'b0;
         if (!eng_busy && fft_start) begin
            eng_busy <= 1'b1;
            eng_sel  <= fft_sel;
            ecnt     <= 0;
         end else if (eng_busy) begin
            if (ecnt == lat - 1) begin
               eng_busy <= 1'b0;
               eng_done <= 1'b1;
            end
            ecnt <= ecnt + 1;
         end
      end
   end

   assign fft_addr  = AW'(ecnt);
   assign fft_we    = eng_busy && (ecnt < FL);
   assign fft_wdata = eng_sel ? fft_rdata + 16'h0101 : ~fft_rdata;

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   // stimulus walk through the vector table, one sample per strobe
   always @(negedge clk) begin
      in_a = samp(cyc / PER, (cyc / CD) % FL, 1'b0);
      in_b = samp(cyc / PER, (cyc / CD) % FL, 1'b1);
   end

   // monitor
   always @(negedge clk) begin
      if (mon_en && !rst) begin
         if (sample_stb)
            chk((cyc % CD) == 0, "R1 strobe cadence", cyc % CD, 0);
         if (fft_start && !fft_sel)
            chk((cyc % PER) == 0 && cyc >= PER, "R5 start A at boundary", cyc, (cyc / PER) * PER);
         if (fft_start && fft_sel)
            chk(cyc == last_done + 1, "R5 start B after done A", cyc, last_done + 1);
         if (out_valid) begin
            int s, f, k;
            s = cyc - 1;
            f = s / PER - 2;
            k = (s / CD) % FL;
            nout++;
            chk((cyc % CD) == 1 && cyc >= 2 * PER + 1, "R7 out_valid timing", cyc, 2 * PER + 1);
            if (f >= 0) begin
               chk(out_a == ~samp(f, k, 1'b0), "R3 R4 R6 stream A result", out_a, ~samp(f, k, 1'b0));
               chk(out_b == samp(f, k, 1'b1) + 16'h0101, "R3 R4 R6 stream B result", out_b, samp(f, k, 1'b1) + 16'h0101);
            end
         end
         if (eng_done) last_done = cyc;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired cyc=%0d actual=hung expected=done", cyc);
      finish_run();
   end

   initial begin
      // reset state
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R7 reset out_valid", out_valid, 0);
      chk(fft_start == 1'b0, "R7 reset fft_start", fft_start, 0);
      chk(util_clks == '0, "R8 reset util", util_clks, 0);
      chk(overrun == 1'b0, "R9 reset overrun", overrun, 0);
      chk(sample_stb == 1'b1, "R1 strobe in first cycle", sample_stb, 1);
      rst = 1'b0;
      mon_en = 1'b1;

      // normal run: two transforms of 10 busy clocks each
      wait_cyc(60);
      chk(util_clks == 0, "R8 no busy in period 0", util_clks, 0);
      chk(overrun == 1'b0, "R9 no overrun period 0", overrun, 0);
      wait_cyc(PER * 2 - 1);
      chk(util_clks == 0, "R2 R8 util before boundary", util_clks, 0);
      wait_cyc(PER * 2);
      chk(util_clks == CW'(2 * lat), "R2 R8 util after boundary", util_clks, 2 * lat);
      chk(overrun == 1'b0, "R9 both done in time", overrun, 0);
      wait_cyc(330);
      chk(nout == 50, "R6 result word count", nout, 50);
      chk(util_clks == CW'(2 * lat), "R8 util steady", util_clks, 2 * lat);

      // slow engine: stream B cannot finish in the period
      mon_en = 1'b0;
      rst = 1'b1;
      lat = 30;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      wait_cyc(PER * 2 - 1);
      chk(overrun == 1'b0, "R9 overrun not before boundary", overrun, 0);
      wait_cyc(PER * 2);
      chk(overrun == 1'b1, "R9 overrun raised", overrun, 1);
      chk(util_clks == CW'(37), "R8 util counts to boundary", util_clks, 37);

      // reset in mid run, then restart the pipeline
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(overrun == 1'b0, "R9 overrun cleared by reset", overrun, 0);
      chk(out_valid == 1'b0, "R7 out_valid cleared by reset", out_valid, 0);
      chk(util_clks == '0, "R8 util cleared by reset", util_clks, 0);
      lat = 10;
      nout = 0;
      last_done = -10;
      rst = 1'b0;
      mon_en = 1'b1;
      wait_cyc(PER * 2 - 1);
      chk(nout == 0, "R7 no results in periods 0 and 1", nout, 0);
      wait_cyc(160);
      chk(nout == 16, "R6 results after restart", nout, 16);
      finish_run();
   end

endmodule